// File: doc/BRIEF.md
# Pipelined Load-Store Unit

This block carries memory instructions between the register files and a 32-bit on-chip memory bus. Each instruction arrives on an issue port with its access size, a store flag, a base operand (which can be replaced by zero), and either an index operand or a 16-bit immediate. The unit adds these to form the effective address and drives one bus beat the cycle after issue. A 64-bit access is sent as two beats on consecutive cycles. Store data is copied into the addressed byte lanes, and per-byte write enables are set to match.

Load data comes back from single-cycle on-chip RAM. The RAM registers its read data, so the data is valid the cycle after the beat. Bytes and half-words are taken from big-endian lanes and widened to 32 bits. Bytes are always zero-filled. Half-words are zero-filled or sign-extended, chosen per instruction. Narrow and word loads return on a 32-bit integer writeback port. Double-word loads return on a 64-bit floating-point writeback port.

A new instruction is accepted every cycle. The only exception is the cycle in which the second beat of a double-word occupies the bus.

Top module: `lsu_core`

## Requirements
- R1: The bus address is the effective address with its two low bits cleared. The effective address is the sum of two terms. The first term is `iss_base`, or zero when `iss_base_zero` is 1 (in that case `iss_base` is ignored). The second term is `iss_index`, or the sign-extended `iss_imm` when `iss_use_imm` is 1.
- R2: A byte load (`iss_size`=0) returns the byte at offset `ea[1:0]`, zero-filled to 32 bits. Offset 0 is `bus_rdata[31:24]` and offset 3 is `bus_rdata[7:0]`. `iss_signed` has no effect on byte loads.
- R3: A half-word load (`iss_size`=1) returns `bus_rdata[31:16]` when `ea[1]`=0 and `bus_rdata[15:0]` when `ea[1]`=1. The result is sign-extended when `iss_signed`=1 and zero-filled otherwise.
- R4: A word load (`iss_size`=2) issued in cycle T is visible on `gpr_wb_*` in cycle T+2. The writeback carries the issued tag.
- R5: A double-word access (`iss_size`=3) issued in cycle T uses the bus in cycles T+1 and T+2. The first beat goes to the aligned address and the second to that address plus 4. A double-word load is visible on `fpr_wb_*` in cycle T+3 as {first word, second word}. The two writeback ports are never valid in the same cycle.
- R6: Every accepted instruction drives `bus_req` in the next cycle. Instructions of any size are accepted on back-to-back cycles.
- R7: After a double-word is accepted, `iss_ready` is 0 for exactly one cycle and then returns to 1. In every other case it is 1.
- R8: On a store, `bus_be` (bit 3 = lane `[31:24]`) is set by size. A byte store gives 4'b1000 shifted right by `ea[1:0]`. A half-word store gives 4'b1100 when `ea[1]`=0 and 4'b0011 when `ea[1]`=1. Word and double-word stores give 4'b1111. Byte and half-word store data is replicated across all lanes.
- R9: A double-word store sends `iss_wdata[63:32]` on its first beat and `iss_wdata[31:0]` on its second. Stores produce no writeback.
- R10: During reset `bus_req`, `gpr_wb_valid` and `fpr_wb_valid` are 0 and `iss_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | Instruction accepted when high with iss_valid |
| iss_store | input | 1 | 1 = store, 0 = load |
| iss_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 double-word |
| iss_signed | input | 1 | Sign-extend half-word loads |
| iss_base_zero | input | 1 | Use zero instead of iss_base |
| iss_base | input | 32 | Base operand |
| iss_use_imm | input | 1 | Use immediate instead of index |
| iss_index | input | 32 | Index operand |
| iss_imm | input | 16 | Signed immediate offset |
| iss_tag | input | 5 | Destination register number |
| iss_wdata | input | 64 | Store data (low 32 bits for narrow stores) |
| bus_req | output | 1 | Bus beat active |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 32 | Word-aligned beat address |
| bus_be | output | 4 | Byte write enables |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after a read beat |
| gpr_wb_valid | output | 1 | Integer writeback valid |
| gpr_wb_tag | output | 5 | Integer destination |
| gpr_wb_data | output | 32 | Integer writeback data |
| fpr_wb_valid | output | 1 | Floating-point writeback valid |
| fpr_wb_tag | output | 5 | Floating-point destination |
| fpr_wb_data | output | 64 | Floating-point writeback data |

## Verification
The assertions assume three things about the environment:
- The memory always answers a read beat with data in the next cycle, with no wait states.
- `iss_size` and `iss_store` are meaningful whenever `iss_valid` is high.
- Narrow accesses are naturally aligned, so a half-word is never at an odd offset.

The stimulus keeps to these assumptions in several ways. It forms its random addresses from a word index plus an offset chosen legally for the size. It places double-words on 8-byte boundaries. It uses a bench memory model that registers its read data on every read beat. Instructions offered while `iss_ready` is low are counted as not accepted and are not expected on the bus.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              base_zero_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    output logic [ADDR_W-1:0] ea_o
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] op_a;
    logic [ADDR_W-1:0] op_b;

    always_comb begin
        // R1: zero option replaces the base term entirely
        op_a = base_zero_i ? '0 : base_i;
        op_b = use_imm_i ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i} : index_i;
        ea_o = op_a + op_b;
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
(
    input  size_e              size_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [WORD_W-1:0]  data_i,
    output logic [LANES-1:0]   be_o,
    output logic [WORD_W-1:0]  data_o
);
    localparam logic [LANES-1:0] BYTE_TOP = LANES'(1) << (LANES - 1);
    localparam logic [LANES-1:0] HALF_TOP = LANES'(3) << (LANES - 2);

    logic [WORD_W-1:0] byte_rep;
    logic [WORD_W-1:0] half_rep;
    logic [OFF_W-1:0]  half_off;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_byte_rep
            assign byte_rep[8*g +: 8] = data_i[7:0];
        end
        for (genvar g = 0; g < LANES/2; g++) begin : g_half_rep
            assign half_rep[16*g +: 16] = data_i[15:0];
        end
    endgenerate

    assign half_off = {off_i[OFF_W-1:1], 1'b0};

    // Big-endian lanes: offset 0 is the most significant byte
    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                be_o   = BYTE_TOP >> off_i;
                data_o = byte_rep;
            end
            SZ_HALF: begin
                be_o   = HALF_TOP >> half_off;
                data_o = half_rep;
            end
            default: begin
                be_o   = '1;
                data_o = data_i;
            end
        endcase
    end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
    import lsu_pkg::*;
(
    input  size_e              size_i,
    input  logic               sign_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [WORD_W-1:0]  rdata_i,
    output logic [WORD_W-1:0]  word_o
);
    logic [OFF_W-1:0]  byte_idx;
    logic [OFF_W-1:0]  half_idx;
    logic [WORD_W-1:0] byte_sh;
    logic [WORD_W-1:0] half_sh;

    always_comb begin
        byte_idx = OFF_W'(LANES - 1) - off_i;
        half_idx = OFF_W'(LANES - 2) - {off_i[OFF_W-1:1], 1'b0};
        byte_sh  = rdata_i >> {byte_idx, 3'b000};
        half_sh  = rdata_i >> {half_idx, 3'b000};
        unique case (size_i)
            SZ_BYTE: word_o = {{(WORD_W-8){1'b0}}, byte_sh[7:0]};
            SZ_HALF: word_o = {{(WORD_W-16){sign_i & half_sh[15]}}, half_sh[15:0]};
            default: word_o = rdata_i;
        endcase
    end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int TAG_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_valid,
    output logic                  iss_ready,
    input  logic                  iss_store,
    input  logic [1:0]            iss_size,
    input  logic                  iss_signed,
    input  logic                  iss_base_zero,
    input  logic [ADDR_W-1:0]     iss_base,
    input  logic                  iss_use_imm,
    input  logic [ADDR_W-1:0]     iss_index,
    input  logic [IMM_W-1:0]      iss_imm,
    input  logic [TAG_W-1:0]      iss_tag,
    input  logic [2*WORD_W-1:0]   iss_wdata,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [LANES-1:0]      bus_be,
    output logic [WORD_W-1:0]     bus_wdata,
    input  logic [WORD_W-1:0]     bus_rdata,
    output logic                  gpr_wb_valid,
    output logic [TAG_W-1:0]      gpr_wb_tag,
    output logic [WORD_W-1:0]     gpr_wb_data,
    output logic                  fpr_wb_valid,
    output logic [TAG_W-1:0]      fpr_wb_tag,
    output logic [2*WORD_W-1:0]   fpr_wb_data
);
    localparam int DW = 2 * WORD_W;

    typedef struct packed {
        logic               s1_vld;
        logic               s1_store;
        size_e              s1_size;
        logic               s1_sgn;
        logic               s1_beat;
        logic [ADDR_W-1:0]  s1_addr;
        logic [OFF_W-1:0]   s1_off;
        logic [TAG_W-1:0]   s1_tag;
        logic [DW-1:0]      s1_wdata;
        logic               s2_vld;
        size_e              s2_size;
        logic               s2_sgn;
        logic               s2_beat;
        logic [OFF_W-1:0]   s2_off;
        logic [TAG_W-1:0]   s2_tag;
        logic [WORD_W-1:0]  hi;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] ea;
    logic [WORD_W-1:0] lane_src;
    logic [WORD_W-1:0] load_word;
    logic              need_beat2;

    lsu_agen #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) i_agen (
        .base_i      (iss_base),
        .base_zero_i (iss_base_zero),
        .index_i     (iss_index),
        .imm_i       (iss_imm),
        .use_imm_i   (iss_use_imm),
        .ea_o        (ea)
    );

    // High word goes out first; second beat of a double-word carries the low word
    assign lane_src = (st_q.s1_size == SZ_DWORD && !st_q.s1_beat)
                      ? st_q.s1_wdata[DW-1:WORD_W] : st_q.s1_wdata[WORD_W-1:0];

    lsu_store_lane i_lane (
        .size_i (st_q.s1_size),
        .off_i  (st_q.s1_off),
        .data_i (lane_src),
        .be_o   (bus_be),
        .data_o (bus_wdata)
    );

    lsu_load_align i_align (
        .size_i  (st_q.s2_size),
        .sign_i  (st_q.s2_sgn),
        .off_i   (st_q.s2_off),
        .rdata_i (bus_rdata),
        .word_o  (load_word)
    );

    assign need_beat2 = st_q.s1_vld && st_q.s1_size == SZ_DWORD && !st_q.s1_beat;
    assign iss_ready  = !need_beat2;

    always_comb begin
        st_d = st_q;

        // Stage 1: address phase on the bus
        if (need_beat2) begin
            st_d.s1_beat = 1'b1;
            st_d.s1_addr = st_q.s1_addr + ADDR_W'(LANES);
        end else if (iss_valid) begin
            st_d.s1_vld   = 1'b1;
            st_d.s1_store = iss_store;
            st_d.s1_size  = size_e'(iss_size);
            st_d.s1_sgn   = iss_signed;
            st_d.s1_beat  = 1'b0;
            st_d.s1_addr  = {ea[ADDR_W-1:OFF_W], OFF_W'(0)};
            st_d.s1_off   = ea[OFF_W-1:0];
            st_d.s1_tag   = iss_tag;
            st_d.s1_wdata = iss_wdata;
        end else begin
            st_d.s1_vld = 1'b0;
        end

        // Stage 2: read data returns from the RAM
        st_d.s2_vld  = st_q.s1_vld && !st_q.s1_store;
        st_d.s2_size = st_q.s1_size;
        st_d.s2_sgn  = st_q.s1_sgn;
        st_d.s2_beat = st_q.s1_beat;
        st_d.s2_off  = st_q.s1_off;
        st_d.s2_tag  = st_q.s1_tag;

        if (st_q.s2_vld && st_q.s2_size == SZ_DWORD && !st_q.s2_beat) begin
            st_d.hi = bus_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req  = st_q.s1_vld;
    assign bus_we   = st_q.s1_store;
    assign bus_addr = st_q.s1_addr;

    assign gpr_wb_valid = st_q.s2_vld && st_q.s2_size != SZ_DWORD;
    assign gpr_wb_tag   = st_q.s2_tag;
    assign gpr_wb_data  = load_word;

    assign fpr_wb_valid = st_q.s2_vld && st_q.s2_size == SZ_DWORD && st_q.s2_beat;
    assign fpr_wb_tag   = st_q.s2_tag;
    assign fpr_wb_data  = {st_q.hi, bus_rdata};
endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              iss_store,
    input logic [1:0]        iss_size,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic              gpr_wb_valid,
    input logic              fpr_wb_valid
);
    AST_ISSUE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready |=> bus_req); // R6

    AST_READY_ONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready && iss_size == 2'b11 |=> !iss_ready ##1 iss_ready); // R7

    AST_DW_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready && iss_size == 2'b11
        |=> ##1 (bus_req && bus_addr == $past(bus_addr) + ADDR_W'(4))); // R5

    AST_DW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready && !iss_store && iss_size == 2'b11 |=> ##2 fpr_wb_valid); // R5

    AST_NARROW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready && !iss_store && iss_size != 2'b11 |=> ##1 gpr_wb_valid); // R4

    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready && iss_store |=> ##1 (!gpr_wb_valid && !fpr_wb_valid)); // R9

    AST_WB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpr_wb_valid && fpr_wb_valid)); // R5

    AST_STORE_BE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |-> bus_be != 4'b0000); // R8
endmodule

bind lsu_core lsu_core_chk #(.ADDR_W(ADDR_W)) i_lsu_core_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid    (iss_valid),
    .iss_ready    (iss_ready),
    .iss_store    (iss_store),
    .iss_size     (iss_size),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_be       (bus_be),
    .gpr_wb_valid (gpr_wb_valid),
    .fpr_wb_valid (fpr_wb_valid)
);

// File: tb/test_lsu_core.sv
module test_lsu_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic        iss_ready;
    logic        iss_store = 1'b0;
    logic [1:0]  iss_size = 2'd0;
    logic        iss_signed = 1'b0;
    logic        iss_base_zero = 1'b0;
    logic [31:0] iss_base = '0;
    logic        iss_use_imm = 1'b0;
    logic [31:0] iss_index = '0;
    logic [15:0] iss_imm = '0;
    logic [4:0]  iss_tag = '0;
    logic [63:0] iss_wdata = '0;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] bus_rdata = '0;
    logic        gpr_wb_valid, fpr_wb_valid;
    logic [4:0]  gpr_wb_tag, fpr_wb_tag;
    logic [31:0] gpr_wb_data;
    logic [63:0] fpr_wb_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit exp_ready = 1'b1;

    logic        e_bus_v [8];
    logic        e_bus_we[8];
    logic [31:0] e_bus_a [8];
    logic [3:0]  e_bus_be[8];
    logic [31:0] e_bus_wd[8];
    logic        e_gpr_v [8];
    logic [4:0]  e_gpr_t [8];
    logic [31:0] e_gpr_d [8];
    string       e_gpr_r [8];
    logic        e_fpr_v [8];
    logic [4:0]  e_fpr_t [8];
    logic [63:0] e_fpr_d [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_core i_lsu_core (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'hC3A55A3C;
    endfunction

    // RAM model: read data registered, valid the cycle after the beat
    always @(posedge clk) begin
        if (bus_req && !bus_we) bus_rdata <= mem_word(bus_addr);
    end

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'd0) return 4'b1000 >> off;
        if (sz == 2'd1) return off[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_rep(input logic [1:0] sz, input logic [31:0] w);
        if (sz == 2'd0) return {4{w[7:0]}};
        if (sz == 2'd1) return {2{w[15:0]}};
        return w;
    endfunction

    function automatic logic [31:0] exp_load(input logic [1:0] sz, input bit sg,
                                             input logic [1:0] off, input logic [31:0] w);
        logic [31:0] b;
        logic [15:0] h;
        if (sz == 2'd0) begin
            b = w >> (8 * (3 - off));
            return {24'd0, b[7:0]};
        end
        if (sz == 2'd1) begin
            h = off[1] ? w[15:0] : w[31:16];
            return sg ? {{16{h[15]}}, h} : {16'd0, h};
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic check_outputs();
        int s = cyc % 8;
        chk(iss_ready == exp_ready, "R7", "iss_ready", 64'(iss_ready), 64'(exp_ready));
        chk(bus_req == e_bus_v[s], "R6", "bus_req", 64'(bus_req), 64'(e_bus_v[s]));
        if (e_bus_v[s] && bus_req) begin
            chk(bus_addr == e_bus_a[s], "R1", "bus_addr", 64'(bus_addr), 64'(e_bus_a[s]));
            chk(bus_we == e_bus_we[s], "R9", "bus_we", 64'(bus_we), 64'(e_bus_we[s]));
            if (e_bus_we[s]) begin
                chk(bus_be == e_bus_be[s], "R8", "bus_be", 64'(bus_be), 64'(e_bus_be[s]));
                chk(bus_wdata == e_bus_wd[s], "R9", "bus_wdata", 64'(bus_wdata), 64'(e_bus_wd[s]));
            end
        end
        chk(gpr_wb_valid == e_gpr_v[s], "R4", "gpr_wb_valid", 64'(gpr_wb_valid), 64'(e_gpr_v[s]));
        if (e_gpr_v[s] && gpr_wb_valid) begin
            chk(gpr_wb_tag == e_gpr_t[s], "R4", "gpr_wb_tag", 64'(gpr_wb_tag), 64'(e_gpr_t[s]));
            chk(gpr_wb_data == e_gpr_d[s], e_gpr_r[s], "gpr_wb_data", 64'(gpr_wb_data), 64'(e_gpr_d[s]));
        end
        chk(fpr_wb_valid == e_fpr_v[s], "R5", "fpr_wb_valid", 64'(fpr_wb_valid), 64'(e_fpr_v[s]));
        if (e_fpr_v[s] && fpr_wb_valid) begin
            chk(fpr_wb_tag == e_fpr_t[s], "R5", "fpr_wb_tag", 64'(fpr_wb_tag), 64'(e_fpr_t[s]));
            chk(fpr_wb_data == e_fpr_d[s], "R5", "fpr_wb_data", fpr_wb_data, e_fpr_d[s]);
        end
        e_bus_v[s] = 1'b0;
        e_gpr_v[s] = 1'b0;
        e_fpr_v[s] = 1'b0;
    endtask

    task automatic step(input bit v, input bit st, input logic [1:0] sz, input bit sg,
                        input bit bz, input bit ui, input logic [31:0] ea,
                        input logic [4:0] tg, input logic [63:0] wd);
        logic [31:0] al;
        logic [15:0] imm;
        logic [31:0] base;
        int s1, s2, s3;
        @(negedge clk);
        cyc++;
        check_outputs();
        base = $urandom;
        imm  = 16'($urandom);
        if (ui) begin
            if (bz) imm = ea[15:0];
            else    base = ea - {{16{imm[15]}}, imm};
        end
        iss_valid     = v;
        iss_store     = st;
        iss_size      = sz;
        iss_signed    = sg;
        iss_base_zero = bz;
        iss_use_imm   = ui;
        iss_base      = base;
        iss_imm       = imm;
        iss_index     = bz ? ea : ea - base;
        iss_tag       = tg;
        iss_wdata     = wd;
        s1 = (cyc + 1) % 8;
        s2 = (cyc + 2) % 8;
        s3 = (cyc + 3) % 8;
        al = {ea[31:2], 2'b00};
        if (v && exp_ready) begin
            e_bus_v[s1]  = 1'b1;
            e_bus_we[s1] = st;
            e_bus_a[s1]  = al;
            e_bus_be[s1] = exp_be(sz, ea[1:0]);
            e_bus_wd[s1] = (sz == 2'd3) ? wd[63:32] : exp_rep(sz, wd[31:0]);
            if (sz == 2'd3) begin
                e_bus_v[s2]  = 1'b1;
                e_bus_we[s2] = st;
                e_bus_a[s2]  = al + 32'd4;
                e_bus_be[s2] = 4'b1111;
                e_bus_wd[s2] = wd[31:0];
            end
            if (!st && sz != 2'd3) begin
                e_gpr_v[s2] = 1'b1;
                e_gpr_t[s2] = tg;
                e_gpr_d[s2] = exp_load(sz, sg, ea[1:0], mem_word(al));
                e_gpr_r[s2] = (sz == 2'd0) ? "R2" : (sz == 2'd1) ? "R3" : "R4";
            end
            if (!st && sz == 2'd3) begin
                e_fpr_v[s3] = 1'b1;
                e_fpr_t[s3] = tg;
                e_fpr_d[s3] = {mem_word(al), mem_word(al + 32'd4)};
            end
            exp_ready = (sz != 2'd3);
        end else begin
            exp_ready = 1'b1;
        end
    endtask

    function automatic logic [31:0] rand_ea(input bit st, input logic [1:0] sz);
        logic [31:0] w;
        logic [1:0]  off;
        if (sz == 2'd3) w = ($urandom % 16) * 2;
        else            w = $urandom % 32;
        off = 2'($urandom);
        if (sz == 2'd1) off[0] = 1'b0;
        if (sz[1])      off = 2'd0;
        return (st ? 32'd128 : 32'd0) + w * 4 + {30'd0, off};
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) begin
            e_bus_v[i] = 1'b0; e_gpr_v[i] = 1'b0; e_fpr_v[i] = 1'b0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: state held during reset
        chk(bus_req == 1'b0, "R10", "bus_req in reset", 64'(bus_req), 64'd0);
        chk(gpr_wb_valid == 1'b0, "R10", "gpr_wb_valid in reset", 64'(gpr_wb_valid), 64'd0);
        chk(fpr_wb_valid == 1'b0, "R10", "fpr_wb_valid in reset", 64'(fpr_wb_valid), 64'd0);
        chk(iss_ready == 1'b1, "R10", "iss_ready in reset", 64'(iss_ready), 64'd1);
        rst_n = 1'b1;

        // Directed corners
        step(1, 0, 2'd2, 0, 1, 0, 32'h0000_0010, 5'd1, 64'd0);  // R1 zero base, garbage base port
        step(1, 0, 2'd2, 0, 0, 1, 32'h0000_0024, 5'd2, 64'd0);  // R1 immediate form
        step(1, 0, 2'd3, 0, 0, 0, 32'h0000_0040, 5'd3, 64'd0);  // R5 double-word load
        step(1, 0, 2'd2, 0, 0, 0, 32'h0000_0008, 5'd4, 64'd0);  // R7 refused in gap
        step(1, 0, 2'd2, 0, 0, 0, 32'h0000_000C, 5'd5, 64'd0);  // R6 accepted after gap
        for (int o = 0; o < 4; o++)                              // R2 every lane, sign flag ignored
            step(1, 0, 2'd0, 1, 0, 0, 32'h0000_0030 + o, 5'(6 + o), 64'd0);
        step(1, 0, 2'd1, 1, 0, 0, 32'h0000_0054, 5'd10, 64'd0); // R3 signed, upper half
        step(1, 0, 2'd1, 1, 0, 0, 32'h0000_0056, 5'd11, 64'd0); // R3 signed, lower half
        step(1, 0, 2'd1, 0, 0, 0, 32'h0000_0056, 5'd12, 64'd0); // R3 zero-fill
        step(1, 1, 2'd3, 0, 0, 0, 32'h0000_0088, 5'd0, 64'h1122334455667788); // R9
        step(1, 1, 2'd3, 0, 0, 0, 32'h0000_0090, 5'd0, 64'h99AABBCCDDEEFF00); // R9 refused
        step(1, 1, 2'd0, 0, 0, 0, 32'h0000_0093, 5'd0, 64'h00000000000000A5); // R8 lane 0
        step(1, 1, 2'd1, 0, 0, 0, 32'h0000_0096, 5'd0, 64'h000000000000BEEF); // R8 low half

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            bit          st = ($urandom % 3) == 0;
            logic [1:0]  sz = 2'($urandom);
            step(($urandom % 4) != 0, st, sz, 1'($urandom), ($urandom % 5) == 0,
                 1'($urandom), rand_ea(st, sz), 5'($urandom),
                 {$urandom, $urandom});
        end
        for (int n = 0; n < 6; n++) step(0, 0, 2'd0, 0, 0, 0, 32'd0, 5'd0, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule